// File: doc/BRIEF.md
# Clock Frequency Qualifier with Hysteresis

This block decides whether a monitored clock may be trusted, judging it against a reference clock that is assumed good. The reference clock drives a programmable measurement window. In each window the block counts the rising edges of the monitored clock and takes the absolute difference between that count and an expected value. Two different limits are applied to this difference. A wide limit decides when a trusted clock has gone bad. A narrow limit decides when a distrusted clock has recovered. The state changes only after a programmable run of consecutive windows that agree, so a clock that sits near a limit does not make the status toggle.

A window with no edges at all is treated as loss of signal. Loss of signal is flagged at once and forces the distrusted state without waiting for the debounce run. A separate raw lock indication from outside is synchronized and filtered: the filtered flag rises only after the raw input has been high for a fixed run of reference cycles, and it drops as soon as the raw input goes low. The edge count of the last window and a one-cycle window-end strobe are also available, so that the count can be read in step with the windows.

The monitored-clock counter runs in its own clock domain. It is carried into the reference domain as a Gray code through a synchronizer chain, so only one bit can change between two samples.

Top module: `fmon_top`

## Requirements
- R1: After reset, status_good, los and lock_ok are 0 and meas_count is 0. The distrusted state is the reset state.
- R2: win_done pulses high for one reference cycle every win_len reference cycles. A win_len of 0 behaves as 1. In the cycle where win_done is high, meas_count holds the number of monitored rising edges seen in that window, within ±1 edge of the ideal ratio.
- R3: While status_good is 1, status_good falls only after n_bad consecutive windows whose deviation |meas_count − nominal| is greater than thr_enter. It falls in the cycle after the window-end strobe of the last of those windows, and not earlier.
- R4: While status_good is 0, status_good rises only after n_good consecutive windows whose deviation is at most thr_exit. It rises in the cycle after the window-end strobe of the last of those windows.
- R5: A deviation above thr_exit and at most thr_enter holds the current state indefinitely, whether that state is trusted or distrusted.
- R6: A window that breaks a run restarts it. In the trusted state, a window that passes the thr_enter test clears the failing run. In the distrusted state, a window that fails the thr_exit test clears the passing run.
- R7: A window with a count of 0 sets los and clears status_good in the cycle after its strobe, whatever the failing run was. The first later window with a nonzero count clears los.
- R8: lock_ok rises only after the synchronized lock_raw has been high for LOCK_FILT consecutive reference cycles. It falls within three reference cycles of lock_raw going low. Pulses of lock_raw shorter than LOCK_FILT cycles never raise it.
- R9: A new win_len takes effect from the window that follows. Later strobes are then spaced by the new length, and meas_count scales to match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock; all outputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| mon_clk | input | 1 | Clock under observation |
| lock_raw | input | 1 | Unfiltered lock indication from outside, asynchronous |
| win_len | input | TW (16) | Measurement window length in reference cycles |
| nominal | input | CW (16) | Expected edge count per window |
| thr_enter | input | CW (16) | Deviation above which a trusted clock counts a failing window |
| thr_exit | input | CW (16) | Deviation at or below which a distrusted clock counts a passing window |
| n_bad | input | RW (4) | Consecutive failing windows needed to distrust (0 acts as 1) |
| n_good | input | RW (4) | Consecutive passing windows needed to trust (0 acts as 1) |
| status_good | output | 1 | Qualified status: 1 means the clock is trusted |
| los | output | 1 | Loss of signal: the last window had no edges |
| lock_ok | output | 1 | Filtered lock flag |
| meas_count | output | CW (16) | Edge count of the last completed window |
| win_done | output | 1 | One-cycle strobe marking a new meas_count |

## Verification
The bench aims at the run boundaries. It checks the status one window before and exactly at the n_bad and n_good limits, so a counter off by one would flip a window early or late. It holds the clock inside the band between the two limits from both states, where a design with only one limit would chatter or leave its state. It interleaves a single bad window into a passing run, and the reverse, which a design that does not clear its runs would misjudge. It stops the clock to show that loss of signal bypasses the debounce run. It drives lock chatter shorter than the filter length, which an unfiltered path would pass through.

// File: rtl/fmon_pkg.sv
`timescale 1ns/1ps
package fmon_pkg;
   typedef enum logic {
      QS_BAD  = 1'b0,
      QS_GOOD = 1'b1
   } qual_state_t;
endpackage

// File: rtl/fmon_sync.sv
`timescale 1ns/1ps
module fmon_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fmon_sync: STAGES must be at least 2");
      end
      for (genvar k = 0; k < STAGES; k++) begin : stg
         logic [W-1:0] r;
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= stg[k-1].r;
            end
         end
      end
   endgenerate
   assign q = stg[STAGES-1].r;
endmodule

// File: rtl/fmon_edge_cnt.sv
`timescale 1ns/1ps
module fmon_edge_cnt #(
   parameter int CW   = 16,
   parameter int SYNC = 2
) (
   input  logic          mon_clk,
   input  logic          ref_clk,
   input  logic          rst_n,
   output logic [CW-1:0] edge_bin
);
   logic [CW-1:0] bin_q, gray_q, bin_nx, gray_ref;

   generate
      if (CW < 2) begin : g_bad_cw
         $error("fmon_edge_cnt: CW must be at least 2");
      end
   endgenerate

   assign bin_nx = bin_q + 1'b1;

   always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   fmon_sync #(.W(CW), .STAGES(SYNC)) u_gsync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (gray_q),
      .q     (gray_ref)
   );

   always_comb begin
      edge_bin[CW-1] = gray_ref[CW-1];
      for (int i = CW - 2; i >= 0; i--) edge_bin[i] = edge_bin[i+1] ^ gray_ref[i];
   end

   // R2: the crossing code moves by one bit per monitored edge
   assert_gray_step_R2: assert property (@(posedge mon_clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/fmon_window.sv
`timescale 1ns/1ps
module fmon_window #(
   parameter int CW = 16,
   parameter int TW = 16
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic [TW-1:0] win_len,
   input  logic [CW-1:0] edge_bin,
   output logic          win_done,
   output logic [CW-1:0] meas
);
   logic [TW-1:0] tmr, win_eff;
   logic [CW-1:0] prev;
   logic          last;

   assign win_eff = (win_len == '0) ? TW'(1) : win_len;
   assign last    = (tmr >= win_eff - 1'b1);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr      <= '0;
         win_done <= 1'b0;
         meas     <= '0;
         prev     <= '0;
      end else begin
         win_done <= last;
         if (last) begin
            tmr  <= '0;
            meas <= edge_bin - prev;
            prev <= edge_bin;
         end else begin
            tmr  <= tmr + 1'b1;
         end
      end
   end

   // R2: strobes are separated by the window length
   assert_strobe_gap_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (win_done && win_eff > TW'(1)) |=> !win_done);
   // R2: the result only moves at a window end
   assert_meas_hold_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !$past(last) |-> $stable(meas));
endmodule

// File: rtl/fmon_qual.sv
`timescale 1ns/1ps
module fmon_qual
   import fmon_pkg::*;
#(
   parameter int CW = 16,
   parameter int RW = 4
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic [CW-1:0] meas,
   input  logic [CW-1:0] nominal,
   input  logic [CW-1:0] thr_enter,
   input  logic [CW-1:0] thr_exit,
   input  logic [RW-1:0] n_bad,
   input  logic [RW-1:0] n_good,
   output logic          status_good,
   output logic          los
);
   qual_state_t   st;
   logic [RW-1:0] bad_run, good_run, nb_eff, ng_eff;
   logic [CW-1:0] dev;
   logic          zero_win, fail_win, pass_win;
   logic          bad_done, good_done;

   assign dev       = (meas >= nominal) ? (meas - nominal) : (nominal - meas);
   assign zero_win  = (meas == '0);
   assign fail_win  = (dev > thr_enter);
   assign pass_win  = (dev <= thr_exit);
   assign nb_eff    = (n_bad  == '0) ? RW'(1) : n_bad;
   assign ng_eff    = (n_good == '0) ? RW'(1) : n_good;
   assign bad_done  = ({1'b0, bad_run}  + 1'b1) >= {1'b0, nb_eff};
   assign good_done = ({1'b0, good_run} + 1'b1) >= {1'b0, ng_eff};

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= QS_BAD;
         bad_run  <= '0;
         good_run <= '0;
      end else if (strobe) begin
         if (zero_win) begin
            st       <= QS_BAD;
            bad_run  <= '0;
            good_run <= '0;
         end else if (st == QS_GOOD) begin
            good_run <= '0;
            if (!fail_win)     bad_run <= '0;
            else if (bad_done) begin
               st      <= QS_BAD;
               bad_run <= '0;
            end else           bad_run <= bad_run + 1'b1;
         end else begin
            bad_run <= '0;
            if (!pass_win)      good_run <= '0;
            else if (good_done) begin
               st       <= QS_GOOD;
               good_run <= '0;
            end else            good_run <= good_run + 1'b1;
         end
      end
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)      los <= 1'b0;
      else if (strobe) los <= zero_win;
   end

   assign status_good = (st == QS_GOOD);

   // R7: a lost clock is never trusted
   assert_los_forces_bad_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      los |-> !status_good);
   // R3: the failing run never reaches the limit without a state change
   assert_bad_run_bound_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      bad_run < nb_eff);
   // R4: a window outside the exit limit keeps a distrusted clock distrusted
   assert_exit_gate_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!status_good && strobe && !pass_win) |=> !status_good);
   // R5: the state only moves on a window end
   assert_hold_between_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !strobe |=> $stable(status_good));
endmodule

// File: rtl/fmon_lock_filt.sv
`timescale 1ns/1ps
module fmon_lock_filt #(
   parameter int SYNC      = 2,
   parameter int LOCK_FILT = 16
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic lock_raw,
   output logic lock_ok
);
   localparam int LW = $clog2(LOCK_FILT + 1);

   logic          s;
   logic [LW-1:0] run;

   generate
      if (LOCK_FILT < 1) begin : g_bad_filt
         $error("fmon_lock_filt: LOCK_FILT must be at least 1");
      end
   endgenerate

   fmon_sync #(.W(1), .STAGES(SYNC)) u_lsync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (lock_raw),
      .q     (s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= '0;
         lock_ok <= 1'b0;
      end else if (!s) begin
         run     <= '0;
         lock_ok <= 1'b0;
      end else if (run == LW'(LOCK_FILT)) begin
         lock_ok <= 1'b1;
      end else begin
         run     <= run + 1'b1;
      end
   end

   // R8: a low synchronized input clears the flag on the next edge
   assert_lock_drop_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !s |=> !lock_ok);
   // R8: the flag only rises while the input is held high
   assert_lock_rise_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(lock_ok) |-> s);
endmodule

// File: rtl/fmon_top.sv
`timescale 1ns/1ps
module fmon_top #(
   parameter int CW        = 16,
   parameter int TW        = 16,
   parameter int RW        = 4,
   parameter int SYNC      = 2,
   parameter int LOCK_FILT = 16
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic          mon_clk,
   input  logic          lock_raw,
   input  logic [TW-1:0] win_len,
   input  logic [CW-1:0] nominal,
   input  logic [CW-1:0] thr_enter,
   input  logic [CW-1:0] thr_exit,
   input  logic [RW-1:0] n_bad,
   input  logic [RW-1:0] n_good,
   output logic          status_good,
   output logic          los,
   output logic          lock_ok,
   output logic [CW-1:0] meas_count,
   output logic          win_done
);
   logic [CW-1:0] edge_bin;

   fmon_edge_cnt #(.CW(CW), .SYNC(SYNC)) u_cnt (
      .mon_clk  (mon_clk),
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .edge_bin (edge_bin)
   );

   fmon_window #(.CW(CW), .TW(TW)) u_win (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .win_len  (win_len),
      .edge_bin (edge_bin),
      .win_done (win_done),
      .meas     (meas_count)
   );

   fmon_qual #(.CW(CW), .RW(RW)) u_qual (
      .ref_clk     (ref_clk),
      .rst_n       (rst_n),
      .strobe      (win_done),
      .meas        (meas_count),
      .nominal     (nominal),
      .thr_enter   (thr_enter),
      .thr_exit    (thr_exit),
      .n_bad       (n_bad),
      .n_good      (n_good),
      .status_good (status_good),
      .los         (los)
   );

   fmon_lock_filt #(.SYNC(SYNC), .LOCK_FILT(LOCK_FILT)) u_lock (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .lock_raw (lock_raw),
      .lock_ok  (lock_ok)
   );
endmodule

// File: tb/tb_fmon_top.sv
`timescale 1ns/1ps
module tb_fmon_top;
   localparam real CLK_P = 10.0;
   localparam int  CW = 16, TW = 16, RW = 4, LF = 16;
   localparam int  NB = 3, NG = 4;

   logic          ref_clk = 0, rst_n = 0, mon_clk = 0, lock_raw = 0;
   logic [TW-1:0] win_len = 16'd200;
   logic [CW-1:0] nominal = 16'd100, thr_enter = 16'd12, thr_exit = 16'd4;
   logic [RW-1:0] n_bad = RW'(NB), n_good = RW'(NG);
   logic          status_good, los, lock_ok, win_done;
   logic [CW-1:0] meas_count;

   int  errors = 0, checks = 0;
   real mon_half = 10.0;
   bit  mon_run = 1;
   bit  m_good = 0;
   int  m_brun = 0, m_grun = 0;

   fmon_top #(.CW(CW), .TW(TW), .RW(RW), .SYNC(2), .LOCK_FILT(LF)) dut (
      .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .lock_raw(lock_raw),
      .win_len(win_len), .nominal(nominal), .thr_enter(thr_enter), .thr_exit(thr_exit),
      .n_bad(n_bad), .n_good(n_good), .status_good(status_good), .los(los),
      .lock_ok(lock_ok), .meas_count(meas_count), .win_done(win_done));

   always #(CLK_P/2) ref_clk = ~ref_clk;
   always begin
      if (mon_run) #(mon_half) mon_clk = ~mon_clk;
      else         #(CLK_P);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // class 0: deviation ~0, class 1: ~9 (between limits), class 2: ~20
   function automatic real half_of(input int cls);
      return (cls == 0) ? 10.0 : (cls == 1) ? 11.0 : 12.5;
   endfunction

   function automatic bit exp_after(input int cls);
      if (m_good) begin
         if (cls == 2) begin
            m_brun++;
            if (m_brun >= NB) begin m_good = 0; m_brun = 0; end
         end else m_brun = 0;
      end else begin
         if (cls == 0) begin
            m_grun++;
            if (m_grun >= NG) begin m_good = 1; m_grun = 0; end
         end else m_grun = 0;
      end
      return m_good;
   endfunction

   // returns at the negedge after the qualifier has consumed a window
   task automatic wait_win();
      do @(negedge ref_clk); while (!win_done);
      @(negedge ref_clk);
   endtask

   task automatic run_win(input int cls, input int n, input string req, input bit final_only);
      mon_half = half_of(cls);
      for (int i = 0; i < n; i++) begin
         bit e;
         wait_win();
         e = exp_after(cls);
         if (!final_only || i == n - 1) chk(status_good == e, req, status_good, e);
      end
   endtask

   task automatic gap_check(input int exp_gap, input int lo, input int hi, input string req);
      int g = 0;
      do @(negedge ref_clk); while (!win_done);
      do begin @(negedge ref_clk); g++; end while (!win_done);
      chk(g == exp_gap, req, g, exp_gap);
      chk(meas_count >= lo && meas_count <= hi, req, meas_count, (lo + hi) / 2);
      @(negedge ref_clk);
   endtask

   initial begin
      #(200000 * CLK_P);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge ref_clk);
      // R1 reset values
      chk(status_good == 0, "R1", status_good, 0);
      chk(los == 0, "R1", los, 0);
      chk(lock_ok == 0, "R1", lock_ok, 0);
      chk(meas_count == 0, "R1", meas_count, 0);
      rst_n = 1;

      // R4 start-up qualification: NG-1 windows still distrusted, NG-th trusted
      mon_half = 10.0;
      for (int i = 1; i <= NG; i++) begin
         wait_win();
         chk(status_good == (i == NG), "R4", status_good, (i == NG));
      end
      m_good = 1;

      // R2 strobe spacing and count near 100
      gap_check(200, 99, 101, "R2");

      // R5 band from trusted state holds
      run_win(1, 5, "R5", 0);
      // R3 failing run: trusted for NB-1 windows, distrusted at NB
      run_win(2, NB, "R3", 0);
      // R5 band from distrusted state holds
      run_win(1, 5, "R5", 0);
      // R6 a failing window inside a passing run restarts it
      run_win(0, 2, "R6", 0);
      run_win(2, 1, "R6", 0);
      run_win(0, NG - 1, "R6", 0);
      run_win(0, 1, "R6", 0);
      // R6 a passing window inside a failing run restarts it
      run_win(2, 2, "R6", 0);
      run_win(0, 1, "R6", 0);
      run_win(2, NB - 1, "R6", 0);
      run_win(2, 1, "R6", 0);
      run_win(0, NG, "R4", 1);

      // R7 stop the clock: a zero window distrusts at once
      mon_run = 0;
      wait_win();
      wait_win();
      chk(los == 1, "R7", los, 1);
      chk(meas_count == 0, "R7", meas_count, 0);
      chk(status_good == 0, "R7", status_good, 0);
      mon_run = 1; mon_half = 10.0;
      wait_win();
      chk(los == 0, "R7", los, 0);
      chk(status_good == 0, "R7", status_good, 0);
      m_good = 0; m_brun = 0; m_grun = 1;

      // constrained random windows against the model (R3..R6)
      for (int k = 0; k < 40; k++) begin
         int cls = int'($urandom_range(2, 0));
         run_win(cls, 1, "R6", 0);
      end

      // R9 shorter window takes effect
      win_len = 16'd100; nominal = 16'd50;
      mon_half = 10.0;
      wait_win();
      gap_check(100, 49, 51, "R9");

      // R8 lock filter: chatter never passes
      for (int r = 0; r < 6; r++) begin
         lock_raw = 1;
         for (int c = 0; c < LF - 6; c++) begin
            @(negedge ref_clk);
            chk(lock_ok == 0, "R8", lock_ok, 0);
         end
         lock_raw = 0;
         repeat (3) @(negedge ref_clk);
      end
      lock_raw = 1;
      repeat (LF - 2) @(negedge ref_clk);
      chk(lock_ok == 0, "R8", lock_ok, 0);
      repeat (8) @(negedge ref_clk);
      chk(lock_ok == 1, "R8", lock_ok, 1);
      lock_raw = 0;
      @(negedge ref_clk);
      chk(lock_ok == 1, "R8", lock_ok, 1);
      repeat (3) @(negedge ref_clk);
      chk(lock_ok == 0, "R8", lock_ok, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule